// File: doc/BRIEF.md
# Binary and Decimal Adder Unit

This block is the 8-bit arithmetic unit of an accumulator machine. A caller presents an operation code, the accumulator, a second operand and the current five-bit flag vector, pulses `op_valid_i`, and one clock later reads a registered result and a new flag vector. Four binary operations are supported: plain add, add with the incoming carry, subtract, and subtract with the incoming carry used as a borrow. All of them rewrite every flag.

A decimal-adjust operation turns the accumulator, after a binary add of two packed BCD bytes, back into two valid BCD digits. It applies the correction one nibble at a time, driven by the auxiliary carry and carry flags.

A separate 16-bit path adds two register pairs. It changes only the carry flag, and its sum is held in its own output register.

Top module: `bcd_arith_unit`

## Requirements
- R1: With code 0 (add), result is (acc + operand) mod 256 and carry (flag bit 0) is set exactly when the true sum exceeds 255.
- R2: With code 1 (add with carry), the incoming carry bit (flags_i bit 0) is added as a third term; result and carry follow R1 on the three-term sum.
- R3: With code 2 (subtract), result is (acc - operand) mod 256 and carry is set exactly when operand > acc (borrow out of bit 7).
- R4: With code 3 (subtract with borrow), the incoming carry bit is also subtracted; carry is set exactly when operand + incoming carry > acc.
- R5: For codes 0 to 3 the auxiliary flag (bit 2) is the carry out of bit 3 for additions and the borrow into bit 4 for subtractions (low nibble of acc smaller than low nibble of operand plus carry-in).
- R6: For codes 0 to 4, sign (bit 4) equals result bit 7, zero (bit 3) is set when the result is 0, and parity (bit 1) is set when the result has an even number of ones.
- R7: With code 4 (decimal adjust), 6 is added when the low nibble of acc exceeds 9 or the incoming auxiliary flag is set; the new auxiliary flag is the carry out of bit 3 of that correction.
- R8: In decimal adjust, 0x60 is also added when the high nibble after the low correction exceeds 9, the low correction overflowed 8 bits, or the incoming carry is set; carry out is the incoming carry OR the overflow of the full correction.
- R9: With code 5 (pair add), pair_sum_o becomes (pair_a + pair_b) mod 65536 and carry is set only on overflow past 16 bits; flag bits 4..1 copy flags_i and result_o copies acc_i. pair_sum_o changes only on this code.
- R10: Codes 6 and 7 are no-operations: result_o copies acc_i, flags_o copies flags_i, pair_sum_o holds.
- R11: Outputs are registered: res_valid_o is high in exactly the cycle after a cycle with op_valid_i high, and while op_valid_i is low all data outputs hold.
- R12: An active-low reset clears result_o, flags_o, pair_sum_o and res_valid_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Launch the operation on the inputs this cycle |
| op_sel_i | input | 3 | Operation code (0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 decimal adjust, 5 pair add, 6/7 no-op) |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 5 | Incoming flags {sign, zero, aux, parity, carry} |
| pair_a_i | input | 16 | First register pair for the pair add |
| pair_b_i | input | 16 | Second register pair for the pair add |
| result_o | output | 8 | Registered 8-bit result |
| flags_o | output | 5 | Registered flags, same layout as flags_i |
| pair_sum_o | output | 16 | Registered pair sum |
| res_valid_o | output | 1 | High one cycle after an accepted operation |

## Verification
The properties take for granted that every input carries a known value at each rising edge where op_valid_i is high, and that op_valid_i stays low while reset is asserted. All eight codes count as legal, so nothing is assumed about op_sel_i. The stimulus changes inputs only on the falling edge and keeps the launch strobe low through reset. It mixes directed nibble and byte boundary cases (0x0F+1, 0xFF+1, borrow from zero, 0x9A and 0xFA adjustments, 0xFFFF+1) with random codes, data and idle gaps.

// File: rtl/bcd_arith_pkg.sv
`timescale 1ns/1ps
package bcd_arith_pkg;

   localparam int NIB_W  = 4;
   localparam int FLAG_W = 5;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADC  = 3'd1,
      OP_SUB  = 3'd2,
      OP_SBB  = 3'd3,
      OP_DADJ = 3'd4,
      OP_PAIR = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } arith_op_e;

   typedef struct packed {
      logic sign;
      logic zero;
      logic aux;
      logic parity;
      logic carry;
   } flag_t;

endpackage

// File: rtl/bcd_arith_addsub.sv
`timescale 1ns/1ps
module bcd_arith_addsub #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o,
   output logic              aux_o
);
   localparam int NIBS = DATA_W / NIB_W;

   if (DATA_W % NIB_W != 0) begin : g_bad_nib
      $error("addsub: DATA_W must be a multiple of NIB_W");
   end

   logic [DATA_W-1:0] b_eff;
   logic [NIBS:0]     chain;

   // subtraction runs as a + ~b + ~borrow; carry out is the inverted borrow
   assign b_eff    = sub_i ? ~b_i : b_i;
   assign chain[0] = sub_i ? ~cin_i : cin_i;

   for (genvar n = 0; n < NIBS; n++) begin : g_nib
      logic [NIB_W:0] part;
      assign part = {1'b0, a_i[n*NIB_W +: NIB_W]}
                  + {1'b0, b_eff[n*NIB_W +: NIB_W]}
                  + {{NIB_W{1'b0}}, chain[n]};
      assign sum_o[n*NIB_W +: NIB_W] = part[NIB_W-1:0];
      assign chain[n+1] = part[NIB_W];
   end

   assign carry_o = chain[NIBS] ^ sub_i;
   assign aux_o   = chain[1] ^ sub_i;
endmodule

// File: rtl/bcd_arith_dadj.sv
`timescale 1ns/1ps
module bcd_arith_dadj #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              aux_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] res_o,
   output logic              aux_o,
   output logic              carry_o
);
   localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
   localparam logic [DATA_W-1:0] LO_FIX    = DATA_W'(6);
   localparam logic [DATA_W-1:0] HI_FIX    = DATA_W'(6 << NIB_W);

   if (DATA_W != 2*NIB_W) begin : g_bad_w
      $error("dadj: exactly two digits per byte are supported");
   end

   logic              lo_fix, hi_fix;
   logic [DATA_W-1:0] lo_add, hi_add, corr;
   logic [DATA_W:0]   stage1, total;
   logic [NIB_W:0]    lo_sum;

   assign lo_fix = (a_i[NIB_W-1:0] > DIGIT_MAX) | aux_i;
   assign lo_add = lo_fix ? LO_FIX : {DATA_W{1'b0}};
   assign stage1 = {1'b0, a_i} + {1'b0, lo_add};

   // high digit decision looks at the value after the low correction
   assign hi_fix = (stage1[2*NIB_W-1:NIB_W] > DIGIT_MAX) | carry_i | stage1[DATA_W];
   assign hi_add = hi_fix ? HI_FIX : {DATA_W{1'b0}};
   assign corr   = lo_add | hi_add;

   assign total  = {1'b0, a_i} + {1'b0, corr};
   assign lo_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, corr[NIB_W-1:0]};

   assign res_o   = total[DATA_W-1:0];
   assign carry_o = carry_i | total[DATA_W];
   assign aux_o   = lo_sum[NIB_W];
endmodule

// File: rtl/bcd_arith_pair.sv
`timescale 1ns/1ps
module bcd_arith_pair #(
   parameter int PAIR_W    = 16,
   parameter int SEG_W     = 8,
   parameter bit SEGMENTED = 1'b1
) (
   input  logic [PAIR_W-1:0] a_i,
   input  logic [PAIR_W-1:0] b_i,
   output logic [PAIR_W-1:0] sum_o,
   output logic              carry_o
);
   if (PAIR_W % SEG_W != 0) begin : g_bad_seg
      $error("pair: PAIR_W must be a multiple of SEG_W");
   end

   if (SEGMENTED) begin : g_seg
      localparam int SEGS = PAIR_W / SEG_W;
      logic [SEGS:0] cc;
      assign cc[0] = 1'b0;
      for (genvar s = 0; s < SEGS; s++) begin : g_s
         logic [SEG_W:0] part;
         assign part = {1'b0, a_i[s*SEG_W +: SEG_W]}
                     + {1'b0, b_i[s*SEG_W +: SEG_W]}
                     + {{SEG_W{1'b0}}, cc[s]};
         assign sum_o[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
         assign cc[s+1] = part[SEG_W];
      end
      assign carry_o = cc[SEGS];
   end else begin : g_flat
      logic [PAIR_W:0] whole;
      assign whole   = {1'b0, a_i} + {1'b0, b_i};
      assign sum_o   = whole[PAIR_W-1:0];
      assign carry_o = whole[PAIR_W];
   end
endmodule

// File: rtl/bcd_arith_szp.sv
`timescale 1ns/1ps
module bcd_arith_szp #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] val_i,
   output logic              sign_o,
   output logic              zero_o,
   output logic              parity_o
);
   assign sign_o   = val_i[DATA_W-1];
   assign zero_o   = (val_i == '0);
   assign parity_o = ~^val_i;
endmodule

// File: rtl/bcd_arith_unit.sv
`timescale 1ns/1ps
module bcd_arith_unit
   import bcd_arith_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int PAIR_W         = 16,
   parameter bit PAIR_SEGMENTED = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              op_valid_i,
   input  logic [2:0]        op_sel_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [4:0]        flags_i,
   input  logic [PAIR_W-1:0] pair_a_i,
   input  logic [PAIR_W-1:0] pair_b_i,
   output logic [DATA_W-1:0] result_o,
   output logic [4:0]        flags_o,
   output logic [PAIR_W-1:0] pair_sum_o,
   output logic              res_valid_o
);
   if (DATA_W != 2*NIB_W) begin : g_bad_data
      $error("unit: DATA_W must hold two decimal digits");
   end
   if (PAIR_W != 2*DATA_W) begin : g_bad_pair
      $error("unit: PAIR_W must be twice DATA_W");
   end

   arith_op_e op;
   flag_t     fin;
   assign op  = arith_op_e'(op_sel_i);
   assign fin = flag_t'(flags_i);

   logic is_sub, use_cin, is_bin;
   assign is_sub  = (op == OP_SUB) || (op == OP_SBB);
   assign use_cin = (op == OP_ADC) || (op == OP_SBB);
   assign is_bin  = (op == OP_ADD) || (op == OP_ADC) || is_sub;

   logic [DATA_W-1:0] as_sum;
   logic              as_carry, as_aux;
   bcd_arith_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
      .a_i     (acc_i),
      .b_i     (opnd_i),
      .cin_i   (use_cin & fin.carry),
      .sub_i   (is_sub),
      .sum_o   (as_sum),
      .carry_o (as_carry),
      .aux_o   (as_aux)
   );

   logic [DATA_W-1:0] dj_res;
   logic              dj_aux, dj_carry;
   bcd_arith_dadj #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dadj (
      .a_i     (acc_i),
      .aux_i   (fin.aux),
      .carry_i (fin.carry),
      .res_o   (dj_res),
      .aux_o   (dj_aux),
      .carry_o (dj_carry)
   );

   logic [PAIR_W-1:0] pr_sum;
   logic              pr_carry;
   bcd_arith_pair #(.PAIR_W(PAIR_W), .SEG_W(DATA_W), .SEGMENTED(PAIR_SEGMENTED)) u_pair (
      .a_i     (pair_a_i),
      .b_i     (pair_b_i),
      .sum_o   (pr_sum),
      .carry_o (pr_carry)
   );

   logic [DATA_W-1:0] szp_in;
   logic              szp_s, szp_z, szp_p;
   assign szp_in = is_bin ? as_sum : dj_res;
   bcd_arith_szp #(.DATA_W(DATA_W)) u_szp (
      .val_i    (szp_in),
      .sign_o   (szp_s),
      .zero_o   (szp_z),
      .parity_o (szp_p)
   );

   logic [DATA_W-1:0] res_q, nxt_res;
   flag_t             flg_q, nxt_flg;
   logic [PAIR_W-1:0] pair_q, nxt_pair;
   logic              vld_q;

   always_comb begin
      nxt_res  = acc_i;
      nxt_flg  = fin;
      nxt_pair = pair_q;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            nxt_res       = as_sum;
            nxt_flg.carry = as_carry;
            nxt_flg.aux   = as_aux;
         end
         OP_DADJ: begin
            nxt_res       = dj_res;
            nxt_flg.carry = dj_carry;
            nxt_flg.aux   = dj_aux;
         end
         OP_PAIR: begin
            nxt_flg.carry = pr_carry;
            nxt_pair      = pr_sum;
         end
         default: ;
      endcase
      if (is_bin || (op == OP_DADJ)) begin
         nxt_flg.sign   = szp_s;
         nxt_flg.zero   = szp_z;
         nxt_flg.parity = szp_p;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_q  <= '0;
         flg_q  <= '0;
         pair_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= op_valid_i;
         if (op_valid_i) begin
            res_q  <= nxt_res;
            flg_q  <= nxt_flg;
            pair_q <= nxt_pair;
         end
      end
   end

   assign result_o    = res_q;
   assign flags_o     = flg_q;
   assign pair_sum_o  = pair_q;
   assign res_valid_o = vld_q;
endmodule

// File: rtl/bcd_arith_unit_chk.sv
`timescale 1ns/1ps
module bcd_arith_unit_chk #(
   parameter int DATA_W = 8,
   parameter int PAIR_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              op_valid_i,
   input logic [2:0]        op_sel_i,
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic [4:0]        flags_i,
   input logic [DATA_W-1:0] result_o,
   input logic [4:0]        flags_o,
   input logic [PAIR_W-1:0] pair_sum_o,
   input logic              res_valid_o
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_valid_i |=> res_valid_o); // R11
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !op_valid_i |=> (!res_valid_o && $stable(result_o) && $stable(flags_o) && $stable(pair_sum_o))); // R11
   AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_sel_i == 3'd0) |=>
      ({flags_o[0], result_o} == ({1'b0, $past(acc_i)} + {1'b0, $past(opnd_i)}))); // R1
   AST_SUB_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_sel_i == 3'd2) |=> (flags_o[0] == ($past(opnd_i) > $past(acc_i)))); // R3
   AST_ZERO_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_sel_i <= 3'd4) |=>
      ((flags_o[3] == (result_o == '0)) && (flags_o[4] == result_o[DATA_W-1]))); // R6
   AST_DADJ_CARRY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_sel_i == 3'd4 && flags_i[0]) |=> flags_o[0]); // R8
   AST_PAIR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_sel_i == 3'd5) |=>
      ((flags_o[4:1] == $past(flags_i[4:1])) && (result_o == $past(acc_i)))); // R9
   AST_NOOP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_sel_i >= 3'd6) |=>
      ((result_o == $past(acc_i)) && (flags_o == $past(flags_i)) && $stable(pair_sum_o))); // R10
   AST_BIN_KEEPS_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && op_sel_i <= 3'd4) |=> $stable(pair_sum_o)); // R9
endmodule

bind bcd_arith_unit bcd_arith_unit_chk #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .op_valid_i  (op_valid_i),
   .op_sel_i    (op_sel_i),
   .acc_i       (acc_i),
   .opnd_i      (opnd_i),
   .flags_i     (flags_i),
   .result_o    (result_o),
   .flags_o     (flags_o),
   .pair_sum_o  (pair_sum_o),
   .res_valid_o (res_valid_o)
);

// File: tb/bcd_arith_unit_tb_top.sv
`timescale 1ns/1ps
module bcd_arith_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [7:0]  acc = '0, opnd = '0;
   logic [4:0]  flags_in = '0;
   logic [15:0] pa = '0, pb = '0;
   logic [7:0]  result;
   logic [4:0]  flags_out;
   logic [15:0] pair_sum;
   logic        res_valid;

   always #2 clk = ~clk;

   bcd_arith_unit dut_i (
      .clk_i (clk), .rst_ni (rst_n), .op_valid_i (op_valid), .op_sel_i (op_sel),
      .acc_i (acc), .opnd_i (opnd), .flags_i (flags_in), .pair_a_i (pa), .pair_b_i (pb),
      .result_o (result), .flags_o (flags_out), .pair_sum_o (pair_sum), .res_valid_o (res_valid)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state
   int exp_res = 0, exp_pair = 0, exp_valid = 0;
   int exp_s = 0, exp_z = 0, exp_ac = 0, exp_p = 0, exp_cy = 0;
   string t_res = "R12", t_cy = "R12", t_ac = "R12", t_szp = "R12", t_pair = "R12", t_vld = "R12";

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(t_vld,  "res_valid", int'(res_valid), exp_valid);
      chk(t_res,  "result",    int'(result), exp_res);
      chk(t_cy,   "carry",     int'(flags_out[0]), exp_cy);
      chk(t_ac,   "aux",       int'(flags_out[2]), exp_ac);
      chk(t_szp,  "sign",      int'(flags_out[4]), exp_s);
      chk(t_szp,  "zero",      int'(flags_out[3]), exp_z);
      chk(t_szp,  "parity",    int'(flags_out[1]), exp_p);
      chk(t_pair, "pair_sum",  int'(pair_sum), exp_pair);
   endtask

   task automatic set_szp(input int r);
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      exp_s = (r >> 7) & 1;
      exp_z = (r == 0) ? 1 : 0;
      exp_p = (ones % 2 == 0) ? 1 : 0;
   endtask

   task automatic model(input int op, input int a, input int b, input int f, input int x, input int y);
      int cin, s, corr, v1, t;
      int fcy = f & 1, fac = (f >> 2) & 1;
      exp_valid = 1;
      case (op)
         0, 1: begin
            cin = (op == 1) ? fcy : 0;
            s = a + b + cin;
            exp_res = s & 255; exp_cy = (s > 255) ? 1 : 0;
            exp_ac = (((a & 15) + (b & 15) + cin) > 15) ? 1 : 0;
            set_szp(exp_res);
            t_res = (op == 0) ? "R1" : "R2"; t_cy = t_res; t_ac = "R5"; t_szp = "R6"; t_pair = "R9";
         end
         2, 3: begin
            cin = (op == 3) ? fcy : 0;
            s = a - b - cin;
            exp_res = s & 255; exp_cy = (s < 0) ? 1 : 0;
            exp_ac = ((a & 15) < ((b & 15) + cin)) ? 1 : 0;
            set_szp(exp_res);
            t_res = (op == 2) ? "R3" : "R4"; t_cy = t_res; t_ac = "R5"; t_szp = "R6"; t_pair = "R9";
         end
         4: begin
            corr = (((a & 15) > 9) || fac) ? 6 : 0;
            v1 = a + corr;
            if ((((v1 >> 4) & 15) > 9) || fcy || (v1 > 255)) corr += 96;
            t = a + corr;
            exp_res = t & 255;
            exp_cy = (fcy || (t > 255)) ? 1 : 0;
            exp_ac = (((a & 15) + (corr & 15)) > 15) ? 1 : 0;
            set_szp(exp_res);
            t_res = "R7"; t_cy = "R8"; t_ac = "R7"; t_szp = "R6"; t_pair = "R9";
         end
         5: begin
            s = x + y;
            exp_pair = s & 65535; exp_cy = (s > 65535) ? 1 : 0;
            exp_res = a; exp_ac = fac;
            exp_s = (f >> 4) & 1; exp_z = (f >> 3) & 1; exp_p = (f >> 1) & 1;
            t_res = "R9"; t_cy = "R9"; t_ac = "R9"; t_szp = "R9"; t_pair = "R9";
         end
         default: begin
            exp_res = a; exp_cy = fcy; exp_ac = fac;
            exp_s = (f >> 4) & 1; exp_z = (f >> 3) & 1; exp_p = (f >> 1) & 1;
            t_res = "R10"; t_cy = "R10"; t_ac = "R10"; t_szp = "R10"; t_pair = "R10";
         end
      endcase
      t_vld = "R11";
   endtask

   // drive after a falling edge, check at the falling edge after the capture edge
   task automatic step(input bit v, input int op, input int a, input int b, input int f,
                       input int x, input int y);
      op_valid = v; op_sel = op[2:0]; acc = a[7:0]; opnd = b[7:0];
      flags_in = f[4:0]; pa = x[15:0]; pb = y[15:0];
      if (v) model(op, a, b, f, x, y);
      else begin
         exp_valid = 0;
         t_res = "R11"; t_cy = "R11"; t_ac = "R11"; t_szp = "R11"; t_pair = "R11"; t_vld = "R11";
      end
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare_all(); // R12 reset state
      rst_n = 1'b1;
      // R1 byte wrap and R5 nibble carry
      step(1, 0, 8'hFF, 8'h01, 0, 0, 0);
      step(1, 0, 8'h0F, 8'h01, 0, 0, 0);
      step(1, 0, 8'h00, 8'h00, 5'h1F, 0, 0);
      // R2 carry-in counts
      step(1, 1, 8'hFE, 8'h01, 1, 0, 0);
      step(1, 1, 8'h10, 8'h20, 0, 0, 0);
      // R3 borrow from zero, R4 borrow with carry-in equal operands
      step(1, 2, 8'h00, 8'h01, 0, 0, 0);
      step(1, 2, 8'h10, 8'h01, 0, 0, 0);
      step(1, 3, 8'h55, 8'h55, 1, 0, 0);
      step(1, 3, 8'h55, 8'h54, 1, 0, 0);
      // R7 / R8 decimal adjust corners
      step(1, 4, 8'h9A, 0, 0, 0, 0);
      step(1, 4, 8'h15, 0, 5'b00100, 0, 0);
      step(1, 4, 8'h12, 0, 5'b00001, 0, 0);
      step(1, 4, 8'hFA, 0, 0, 0, 0);
      step(1, 4, 8'h99, 0, 0, 0, 0);
      step(1, 4, 8'h9F, 0, 0, 0, 0);
      // R9 pair add wrap and plain
      step(1, 5, 8'h33, 0, 5'b11110, 16'hFFFF, 16'h0001);
      step(1, 5, 8'h44, 0, 5'b00001, 16'h1234, 16'h4321);
      // R10 no-ops, R11 idle hold
      step(1, 6, 8'hA5, 8'h11, 5'b10101, 16'h1111, 16'h2222);
      step(1, 7, 8'h3C, 8'h22, 5'b01010, 16'h3333, 16'h4444);
      step(0, 0, 8'hFF, 8'hFF, 5'h1F, 16'hFFFF, 16'hFFFF);
      step(0, 5, 8'h01, 8'h01, 0, 16'hFFFF, 16'h0001);
      for (int k = 0; k < 3000; k++) begin
         step(($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 256), int'($urandom % 256),
              int'($urandom % 32), int'($urandom % 65536), int'($urandom % 65536));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule